// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Serial Pin Override

This block is the register and pin-control logic for one eight-bit general-purpose I/O port. Software reaches three registers through a simple synchronous bus: a stored output value, a per-bit direction setting, and a read-only view of the pins. Each pin has an output value and an output enable for the pad, and the pad's input comes back into the block.

Pin inputs pass through a two-flop synchronizer, and every register read sees the synchronized value. Reading the output-value register gives, for each bit, the stored bit when that pin is an output and the synchronized pin level when it is an input. The read-only pin view always returns the synchronized level of all bits.

The lowest four pins can be taken over by two serial interfaces, each with a receive pin (even index) and a transmit pin (odd index). While an interface's enable input is high, it has priority over the GPIO settings on its two pins.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the stored output-value register and the direction register both read 0x00, and with no serial interface enabled every pin_oe bit is low.
- R2: A write at offset 0 updates the stored output value from the next clock edge. pin_out of every non-overridden pin equals its stored bit.
- R3: A write at offset 2 sets the direction register, which reads back at offset 2. For every pin not taken over by a serial interface, pin_oe equals its direction bit (1 = output).
- R4: A read at offset 0 returns, per bit, the stored bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: A read at offset 1 returns the synchronized level of all eight pins, whatever the direction bits are. A write at offset 1 changes neither the stored output value nor the direction register.
- R6: A change on pin_in shows up in register reads after exactly two rising clock edges, and not after one.
- R7: While ser_en[k] is high, pin 2k+1 has pin_oe high and pin_out equal to ser_tx[k], and pin 2k has pin_oe low, whatever the direction and output-value registers hold.
- R8: ser_rx[k] equals the synchronized level of pin 2k while ser_en[k] is high, and is 1 while ser_en[k] is low.
- R9: A write at offset 0 updates the stored bit of a pin that a serial interface currently owns. Once the interface is disabled, that stored bit drives the pin.
- R10: A read at offset 3 returns zero, and a write at offset 3 changes no register.
- R11: The synchronizer that holds the pin view is not cleared by reset: a read at offset 1 while rst_n is low returns the pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset (0 output value, 1 pin view, 2 direction) |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| ser_en | input | 2 | Serial interface enables, bit k for interface k |
| ser_tx | input | 2 | Transmit data of each serial interface |
| ser_rx | output | 2 | Receive data routed to each serial interface |

## Verification
The bench builds the block with its default parameters: eight pins, two serial interfaces and a two-bit offset. With these values the four overridable pins and the four plain GPIO pins sit side by side in every vector, so the direction mux and the override priority are both checked against mixed bit patterns. Offset 3 is reachable as the single unmapped address.

// File: rtl/gpio_pkg.sv
// Package: register offsets shared by the port logic.
// Assumes the bus address is at least two bits wide.
package gpio_pkg;
    localparam int OFS_DATA = 0;   // stored output value, read muxed by direction
    localparam int OFS_PINS = 1;   // read-only synchronized pin view
    localparam int OFS_DIR  = 2;   // direction, 1 = output
endpackage

// File: rtl/pin_sync.sv
// Module: two-flop synchronizer for the pad inputs.
// Assumes pin_in is asynchronous to clk. It has no reset on purpose, so the
// pin view keeps tracking the pads while the block is held in reset.
module pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Two-stage capture of the asynchronous pad levels.
    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end
endmodule

// File: rtl/port_regs.sv
// Module: output-value and direction registers with the bus read mux.
// Assumes a single-cycle write strobe and a combinational read of bus_addr.
module port_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pins_s,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(OFS_PINS);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

    // Stored output value, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (we && addr == A_DATA)   data_q <= wdata;
    end

    // Direction register, all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '0;
        else if (we && addr == A_DIR)    dir_q <= wdata;
    end

    // Read mux; the output-value offset picks per bit by direction.
    always_comb begin
        case (addr)
            A_DATA:  rdata = (dir_q & data_q) | (~dir_q & pins_s);
            A_PINS:  rdata = pins_s;
            A_DIR:   rdata = dir_q;
            default: rdata = '0;
        endcase
    end

    p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DATA) |=> data_q == $past(wdata));

    p_pins_wr_noeff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PINS) |=> ($stable(data_q) && $stable(dir_q)));

    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != A_DATA && addr != A_PINS && addr != A_DIR)
        |=> ($stable(data_q) && $stable(dir_q)));

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/pin_mux.sv
// Module: per-pin output selection between GPIO and the serial interfaces.
// Assumes interface k owns pin 2k (receive) and pin 2k+1 (transmit), and
// that 2*NUM_SER <= WIDTH. The enabled interface always wins over GPIO.
module pin_mux #(
    parameter int WIDTH   = 8,
    parameter int NUM_SER = 2
) (
    input  logic [WIDTH-1:0]   data_q,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [WIDTH-1:0]   pins_s,
    input  logic [NUM_SER-1:0] ser_en,
    input  logic [NUM_SER-1:0] ser_tx,
    output logic [WIDTH-1:0]   pin_out,
    output logic [WIDTH-1:0]   pin_oe,
    output logic [NUM_SER-1:0] ser_rx
);
    localparam int OWNED_PINS = 2 * NUM_SER;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        if (p < OWNED_PINS) begin : g_owned
            localparam int K = p / 2;
            if (p % 2 == 1) begin : g_tx
                // Transmit pin: interface drives and enables the pad.
                assign pin_oe[p]  = ser_en[K] ? 1'b1      : dir_q[p];
                assign pin_out[p] = ser_en[K] ? ser_tx[K] : data_q[p];
            end else begin : g_rx
                // Receive pin: pad driver forced off.
                assign pin_oe[p]  = ser_en[K] ? 1'b0 : dir_q[p];
                assign pin_out[p] = ser_en[K] ? 1'b0 : data_q[p];
            end
        end else begin : g_plain
            // Plain GPIO pin.
            assign pin_oe[p]  = dir_q[p];
            assign pin_out[p] = data_q[p];
        end
    end

    for (genvar k = 0; k < NUM_SER; k++) begin : g_rx_route
        // Receive line idles high while the interface is off.
        assign ser_rx[k] = ser_en[k] ? pins_s[2*k] : 1'b1;
    end
endmodule

// File: rtl/gpio_port_ovr.sv
// Module: top of the GPIO port. Synchronizes the pads, holds the port
// registers and selects between GPIO and serial control per pin.
// Assumes a synchronous active-low reset and that 2*NUM_SER <= WIDTH.
module gpio_port_ovr #(
    parameter int WIDTH   = 8,
    parameter int NUM_SER = 2,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WIDTH-1:0]   bus_wdata,
    output logic [WIDTH-1:0]   bus_rdata,
    input  logic [WIDTH-1:0]   pin_in,
    output logic [WIDTH-1:0]   pin_out,
    output logic [WIDTH-1:0]   pin_oe,
    input  logic [NUM_SER-1:0] ser_en,
    input  logic [NUM_SER-1:0] ser_tx,
    output logic [NUM_SER-1:0] ser_rx
);
    localparam int OWNED_PINS = 2 * NUM_SER;
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(gpio_pkg::OFS_DIR);

    logic [WIDTH-1:0] pins_s;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;

    pin_sync #(.WIDTH(WIDTH)) i_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pins_s)
    );

    port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .pins_s (pins_s),
        .rdata  (bus_rdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    pin_mux #(.WIDTH(WIDTH), .NUM_SER(NUM_SER)) i_mux (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pins_s  (pins_s),
        .ser_en  (ser_en),
        .ser_tx  (ser_tx),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .ser_rx  (ser_rx)
    );

    for (genvar k = 0; k < NUM_SER; k++) begin : g_chk_ser
        p_ser_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ser_en[k] |-> (pin_oe[2*k+1] && !pin_oe[2*k]
                           && pin_out[2*k+1] == ser_tx[k]));
    end

    for (genvar p = OWNED_PINS; p < WIDTH; p++) begin : g_chk_dir
        p_dir_to_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_DIR) |=> pin_oe[p] == $past(bus_wdata[p]));
    end
endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [1:0] ser_en = '0;
    logic [1:0] ser_tx = '0;
    logic [1:0] ser_rx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ovr i_gpio_port_ovr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .ser_en(ser_en),
        .ser_tx(ser_tx), .ser_rx(ser_rx)
    );

    // {dir, data, pins, expected offset-0 read, expected pin_oe}
    localparam logic [39:0] VEC [5] = '{
        {8'hFF, 8'hA5, 8'h3C, 8'hA5, 8'hFF},
        {8'h00, 8'hFF, 8'h5A, 8'h5A, 8'h00},
        {8'hF0, 8'hC3, 8'h0F, 8'hCF, 8'hF0},
        {8'h0F, 8'h96, 8'hE1, 8'hE6, 8'h0F},
        {8'hAA, 8'h55, 8'hFF, 8'h55, 8'hAA}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        pin_in = 8'h77;
        repeat (4) @(negedge clk);
        // R11: pin view readable while reset held
        rd(2'd1, r); check("R11 pin view during reset", r, 8'h77);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(2'd2, r); check("R1 dir after reset", r, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);
        wr(2'd2, 8'hFF);
        rd(2'd0, r); check("R1 data after reset", r, 8'h00);
        wr(2'd2, 8'h00);

        // Table walk: R2 R3 R4 R5
        foreach (VEC[i]) begin
            wr(2'd2, VEC[i][39:32]);
            wr(2'd0, VEC[i][31:24]);
            settle_pins(VEC[i][23:16]);
            rd(2'd0, r); check("R4 muxed read", r, VEC[i][15:8]);
            rd(2'd1, r); check("R5 pin view", r, VEC[i][23:16]);
            rd(2'd2, r); check("R3 dir readback", r, VEC[i][39:32]);
            check("R3 oe", pin_oe, VEC[i][7:0]);
            check("R2 pin_out", pin_out, VEC[i][31:24]);
        end

        // R5: write to pin view ignored
        wr(2'd2, 8'h3C); wr(2'd0, 8'h81);
        wr(2'd1, 8'h5A);
        rd(2'd2, r); check("R5 write at 1 dir", r, 8'h3C);
        check("R5 write at 1 data", pin_out, 8'h81);

        // R10: unmapped offset
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R10 unmapped read", r, 8'h00);
        rd(2'd2, r); check("R10 unmapped write dir", r, 8'h3C);
        check("R10 unmapped write data", pin_out, 8'h81);

        // R6: two-edge latency
        wr(2'd2, 8'h00);
        settle_pins(8'h00);
        @(negedge clk); pin_in = 8'hC6;
        @(negedge clk);
        rd(2'd1, r); check("R6 not after one edge", r, 8'h00);
        @(negedge clk);
        rd(2'd1, r); check("R6 after two edges", r, 8'hC6);

        // R7: interface 0 owns pins 0 and 1
        wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
        @(negedge clk); ser_en = 2'b01; ser_tx = 2'b01; #1;
        check("R7 ser0 oe", pin_oe, 8'hFE);
        check("R7 ser0 tx high", pin_out, 8'h02);
        ser_tx = 2'b00; #1;
        check("R7 ser0 tx low", pin_out, 8'h00);
        // R8: receive routing
        settle_pins(8'h01);
        check("R8 ser0 rx high, ser1 idle", {6'd0, ser_rx}, 8'h03);
        settle_pins(8'h00);
        check("R8 ser0 rx low", {6'd0, ser_rx}, 8'h02);

        // R9: write to owned pin, effective after disable
        wr(2'd0, 8'h02);
        check("R9 owned pin keeps tx", pin_out, 8'h00);
        rd(2'd0, r); check("R9 stored bit", r, 8'h02);
        @(negedge clk); ser_en = 2'b00; #1;
        check("R9 after disable out", pin_out, 8'h02);
        check("R9 after disable oe", pin_oe, 8'hFF);
        check("R8 rx idle when off", {6'd0, ser_rx}, 8'h03);

        // R7: interface 1 owns pins 2 and 3
        wr(2'd2, 8'h04); wr(2'd0, 8'h00);
        @(negedge clk); ser_en = 2'b10; ser_tx = 2'b10; #1;
        check("R7 ser1 oe", pin_oe, 8'h08);
        check("R7 ser1 out", pin_out, 8'h08);
        settle_pins(8'h04);
        check("R8 ser1 rx", {6'd0, ser_rx}, 8'h03);
        ser_en = 2'b00;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule